// File: doc/BRIEF.md
# Age-Ordered Queue Entry Allocator

This block sits between several parallel load pipeline ports and a small pool of tracking entries. In each cycle it takes up to three load requests, sorts them by reorder-buffer age and gives free entries to the eligible ones, oldest first. A bitmap records which entries are free. The downstream logic that owns the entries sends back per-entry release pulses when an entry is finished or flushed, and those slots return to the pool.

When more eligible requests arrive than there are free entries, the block does not stall. It places as many requests as it can, in age order. It then raises a single rollback naming the oldest request that got no entry, so the pipeline can replay that request and everything younger. Each port receives either a registered entry index or nothing. The rollback comes out of a short pipeline two cycles after the request arrived.

Top module: `age_alloc_top`

## Requirements
- R1: Requests on all ports are sampled on the same clock edge. The grant for a request (`alloc_vld` bit and `alloc_idx` field of that port) is visible in the cycle right after the request is presented.
- R2: A request is eligible only when `req_vld` is 1, `req_resend` is 0 and `req_exc` is 0. An ineligible request gets no entry, uses no entry and never causes a rollback.
- R3: Age is a wrap flag plus an index. When the flags are equal, the smaller index is older. When the flags differ, the larger index is older. Requests of equal age are ranked by port number, with the lower port counted as older.
- R4: Eligible requests are served oldest first. The k-th oldest eligible request gets the k-th free entry, with free entries counted from index 0 upward.
- R5: An entry is granted only while it is free, and at most one request gets it. Once granted, it stays out of the pool until it is released.
- R6: If eligible requests are left without an entry, `rb_vld` pulses exactly once for the oldest of them. The pulse comes two cycles after the request was presented, and `rb_flag`/`rb_idx` carry that request's age.
- R7: Any number of entries can be released in one cycle through `rel_mask`, with bit e naming entry e. The released entries can be granted from the next cycle on, but not in the cycle in which they are released.
- R8: While `rst_n` is low on a clock edge, every entry is marked free and `alloc_vld` and `rb_vld` go to 0.
- R9: The number of entries is a parameter, 4 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | NPORT | Request present, one bit per port |
| req_resend | input | NPORT | Request is a re-send and must not be allocated |
| req_exc | input | NPORT | Request carries an exception and must not be allocated |
| req_flag | input | NPORT | Wrap flag of each request's age |
| req_idx | input | NPORT x ROB_W | Reorder-buffer index of each request |
| rel_mask | input | NENT | Release pulses, one bit per entry |
| alloc_vld | output | NPORT | Registered grant, one bit per port |
| alloc_idx | output | NPORT x log2(NENT) | Registered granted entry index per port |
| rb_vld | output | 1 | Rollback pulse |
| rb_flag | output | 1 | Wrap flag of the rolled-back request |
| rb_idx | output | ROB_W | Reorder-buffer index of the rolled-back request |

## Verification
The hardest case to reach from the ports is a partial overflow. In that case the pool holds fewer free entries than there are eligible requests, and the oldest request left over is not on the lowest port. Reaching it needs both the ages and the pool occupancy under control. The stimulus first fills part of the pool with one batch of grants. It then presents a second batch whose ages run opposite to port order, so that one grant lands on a high port and the rollback names a middle port. A release pulse in the same cycle as a new request on a full pool then shows that freed slots cannot be granted until the cycle after.

// File: rtl/alloc_pkg.sv
// Shared helpers for the age-ordered allocator.
// Assumes reorder-buffer indices are no wider than AGE_MAXW bits.
package alloc_pkg;

    localparam int AGE_MAXW = 16;

    // True when age A is strictly older than age B.
    // Equal flags: the smaller index is older. Different flags: the larger index is older.
    function automatic logic age_older(input logic fa, input logic [AGE_MAXW-1:0] ia,
                                       input logic fb, input logic [AGE_MAXW-1:0] ib);
        return (fa == fb) ? (ia < ib) : (ia > ib);
    endfunction

endpackage

// File: rtl/age_rank.sv
// Age ranker: gives each eligible request a rank, which is the number of eligible
// requests older than it. Equal ages are ranked by port number, so ranks are unique.
// Assumes ROB_W <= alloc_pkg::AGE_MAXW. Purely combinational.
module age_rank #(
    parameter int NPORT = 3,
    parameter int ROB_W = 6,
    parameter int CW    = 3
) (
    input  logic [NPORT-1:0]            elig,
    input  logic [NPORT-1:0]            flag,
    input  logic [NPORT-1:0][ROB_W-1:0] idx,
    output logic [NPORT-1:0][CW-1:0]    rank
);
    import alloc_pkg::*;

    // Count, for every port, the eligible ports that are ahead of it in age.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NPORT; j++) begin
                if (j != i && elig[j]) begin
                    if (age_older(flag[j], AGE_MAXW'(idx[j]), flag[i], AGE_MAXW'(idx[i])) ||
                        (flag[j] == flag[i] && idx[j] == idx[i] && j < i))
                        rank[i] = rank[i] + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/slot_pick.sv
// Slot picker: the request of rank k takes the k-th free entry, counted from index 0.
// Assumes the ranks of wanting requests are unique. Purely combinational.
module slot_pick #(
    parameter int NPORT = 3,
    parameter int NENT  = 4,
    parameter int IDX_W = 2,
    parameter int CW    = 3
) (
    input  logic [NENT-1:0]              free,
    input  logic [NPORT-1:0]             want,
    input  logic [NPORT-1:0][CW-1:0]     rank,
    output logic [NPORT-1:0]             placed,
    output logic [NPORT-1:0][IDX_W-1:0]  slot,
    output logic [NENT-1:0]              take
);
    logic [NENT-1:0][CW-1:0] pos;

    // Position of each entry among the free entries: the count of free entries below it.
    always_comb begin
        logic [CW-1:0] cnt;
        cnt = '0;
        for (int e = 0; e < NENT; e++) begin
            pos[e] = cnt;
            if (free[e]) cnt = cnt + CW'(1);
        end
    end

    // Match each request's rank against the free positions to pick its entry.
    always_comb begin
        placed = '0;
        slot   = '0;
        take   = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int e = 0; e < NENT; e++) begin
                if (want[i] && free[e] && pos[e] == rank[i]) begin
                    placed[i] = 1'b1;
                    slot[i]   = IDX_W'(e);
                    take[e]   = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/free_pool.sv
// Free pool: a bitmap of entries that can be granted. A taken entry leaves the pool;
// a released entry comes back and is visible from the next cycle.
// Assumes only busy entries are released and only free entries are taken.
module free_pool #(
    parameter int NENT = 4,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NENT-1:0] take,
    input  logic [NENT-1:0] rel,
    output logic [NENT-1:0] free,
    output logic [CW-1:0]   nfree
);
    // Update the bitmap: remove granted entries and add released ones.
    always_ff @(posedge clk) begin
        if (!rst_n) free <= '1;
        else        free <= (free & ~take) | rel;
    end

    // Number of free entries, used to find the oldest request left without an entry.
    always_comb nfree = CW'($countones(free));

    assert_take_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take & ~free) == '0);
    assert_release_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel & free) == '0);
    assert_taken_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take != '0) |=> ((free & $past(take)) == '0));
endmodule

// File: rtl/rollback_pipe.sv
// Rollback pipe: delays the rollback pulse and the rejected age by STAGES cycles.
// Assumes at most one rollback candidate per cycle.
module rollback_pipe #(
    parameter int ROB_W  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             hit_flag,
    input  logic [ROB_W-1:0] hit_idx,
    output logic             rb_vld,
    output logic             rb_flag,
    output logic [ROB_W-1:0] rb_idx
);
    logic [STAGES-1:0]            v_q;
    logic [STAGES-1:0]            f_q;
    logic [STAGES-1:0][ROB_W-1:0] i_q;

    // Shift the candidate through the delay stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            f_q <= '0;
            i_q <= '0;
        end else begin
            v_q[0] <= hit;
            f_q[0] <= hit_flag;
            i_q[0] <= hit_idx;
            for (int s = 1; s < STAGES; s++) begin
                v_q[s] <= v_q[s-1];
                f_q[s] <= f_q[s-1];
                i_q[s] <= i_q[s-1];
            end
        end
    end

    // The last stage drives the outputs.
    always_comb begin
        rb_vld  = v_q[STAGES-1];
        rb_flag = f_q[STAGES-1];
        rb_idx  = i_q[STAGES-1];
    end
endmodule

// File: rtl/age_alloc_top.sv
// Age-ordered entry allocator: ranks up to NPORT requests by age, grants free entries
// oldest first, and raises a rollback, two cycles later, for the oldest eligible request
// left without an entry. Grants are registered and appear one cycle after the request.
// Assumes release pulses name only entries that are currently granted.
module age_alloc_top #(
    parameter int NPORT = 3,
    parameter int NENT  = 4,
    parameter int ROB_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NPORT-1:0]                     req_vld,
    input  logic [NPORT-1:0]                     req_resend,
    input  logic [NPORT-1:0]                     req_exc,
    input  logic [NPORT-1:0]                     req_flag,
    input  logic [NPORT-1:0][ROB_W-1:0]          req_idx,
    input  logic [NENT-1:0]                      rel_mask,
    output logic [NPORT-1:0]                     alloc_vld,
    output logic [NPORT-1:0][$clog2(NENT)-1:0]   alloc_idx,
    output logic                                 rb_vld,
    output logic                                 rb_flag,
    output logic [ROB_W-1:0]                     rb_idx
);
    localparam int IDX_W  = $clog2(NENT);
    localparam int BIGGER = (NENT > NPORT) ? NENT : NPORT;
    localparam int CW     = $clog2(BIGGER + 1);
    localparam int RB_LAT = 2;

    logic [NPORT-1:0]            elig;
    logic [NPORT-1:0][CW-1:0]    rank;
    logic [NPORT-1:0]            placed;
    logic [NPORT-1:0][IDX_W-1:0] slot;
    logic [NENT-1:0]             take;
    logic [NENT-1:0]             free;
    logic [CW-1:0]               nfree;
    logic                        rb_hit;
    logic                        rb_hit_flag;
    logic [ROB_W-1:0]            rb_hit_idx;

    // Filter out requests that are re-sends or carry an exception.
    always_comb elig = req_vld & ~req_resend & ~req_exc;

    age_rank #(.NPORT(NPORT), .ROB_W(ROB_W), .CW(CW)) u_rank (
        .elig(elig), .flag(req_flag), .idx(req_idx), .rank(rank)
    );

    slot_pick #(.NPORT(NPORT), .NENT(NENT), .IDX_W(IDX_W), .CW(CW)) u_pick (
        .free(free), .want(elig), .rank(rank),
        .placed(placed), .slot(slot), .take(take)
    );

    free_pool #(.NENT(NENT), .CW(CW)) u_pool (
        .clk(clk), .rst_n(rst_n), .take(take), .rel(rel_mask),
        .free(free), .nfree(nfree)
    );

    // The oldest request without an entry is the eligible one whose rank equals the free count.
    always_comb begin
        rb_hit      = 1'b0;
        rb_hit_flag = 1'b0;
        rb_hit_idx  = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (elig[i] && rank[i] == nfree) begin
                rb_hit      = 1'b1;
                rb_hit_flag = req_flag[i];
                rb_hit_idx  = req_idx[i];
            end
        end
    end

    rollback_pipe #(.ROB_W(ROB_W), .STAGES(RB_LAT)) u_rb (
        .clk(clk), .rst_n(rst_n), .hit(rb_hit), .hit_flag(rb_hit_flag), .hit_idx(rb_hit_idx),
        .rb_vld(rb_vld), .rb_flag(rb_flag), .rb_idx(rb_idx)
    );

    // Register the grants for the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld <= '0;
            alloc_idx <= '0;
        end else begin
            alloc_vld <= placed;
            alloc_idx <= slot;
        end
    end

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (placed & ~elig) == '0);
    assert_full_before_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((elig & ~placed) != '0) |-> ($countones(placed) == int'(nfree)));
    assert_rollback_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_vld |-> $past(rb_hit, 2));
    assert_rollback_needs_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rb_hit |-> ((elig & ~placed) != '0));
endmodule

// File: tb/age_alloc_top_test.sv
module age_alloc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 3;
    localparam int NENT  = 4;
    localparam int ROB_W = 6;
    localparam int WATCHDOG = 5000;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [NPORT-1:0]             req_vld = '0;
    logic [NPORT-1:0]             req_resend = '0;
    logic [NPORT-1:0]             req_exc = '0;
    logic [NPORT-1:0]             req_flag = '0;
    logic [NPORT-1:0][ROB_W-1:0]  req_idx = '0;
    logic [NENT-1:0]              rel_mask = '0;
    logic [NPORT-1:0]             alloc_vld;
    logic [NPORT-1:0][1:0]        alloc_idx;
    logic                         rb_vld;
    logic                         rb_flag;
    logic [ROB_W-1:0]             rb_idx;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    age_alloc_top #(.NPORT(NPORT), .NENT(NENT), .ROB_W(ROB_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_resend(req_resend),
        .req_exc(req_exc), .req_flag(req_flag), .req_idx(req_idx), .rel_mask(rel_mask),
        .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
        .rb_vld(rb_vld), .rb_flag(rb_flag), .rb_idx(rb_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clear_in();
        req_vld = '0; req_resend = '0; req_exc = '0; req_flag = '0; req_idx = '0; rel_mask = '0;
    endtask

    task automatic put(input int p, input bit fl, input int idx);
        req_vld[p]  = 1'b1;
        req_flag[p] = fl;
        req_idx[p]  = ROB_W'(idx);
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // R8: reset state
    task automatic t_reset();
        do_reset();
        chk("R8 alloc_vld after reset", int'(alloc_vld), 0);
        chk("R8 rb_vld after reset", int'(rb_vld), 0);
    endtask

    // R1: one request granted the next cycle with entry 0
    task automatic t_single();
        do_reset();
        put(1, 1'b0, 5);
        step();
        clear_in();
        chk("R1 single grant valid", int'(alloc_vld), 3'b010);
        chk("R1 single grant entry", int'(alloc_idx[1]), 0);
        step();
        chk("R1 grant lasts one cycle", int'(alloc_vld), 0);
    endtask

    // R4: ages opposite to port order; oldest takes lowest entry
    task automatic t_order();
        do_reset();
        put(0, 1'b0, 9); put(1, 1'b0, 3); put(2, 1'b0, 6);
        step();
        clear_in();
        chk("R4 all granted", int'(alloc_vld), 3'b111);
        chk("R4 oldest port1 entry", int'(alloc_idx[1]), 0);
        chk("R4 middle port2 entry", int'(alloc_idx[2]), 1);
        chk("R4 youngest port0 entry", int'(alloc_idx[0]), 2);
    endtask

    // R3: differing wrap flags invert the index compare; equal ages go by port
    task automatic t_wrap();
        do_reset();
        put(0, 1'b1, 2); put(1, 1'b0, 60);
        step();
        clear_in();
        chk("R3 wrap older port1 entry", int'(alloc_idx[1]), 0);
        chk("R3 wrap younger port0 entry", int'(alloc_idx[0]), 1);
        put(1, 1'b0, 7); put(2, 1'b0, 7);
        step();
        clear_in();
        chk("R3 tie lower port entry", int'(alloc_idx[1]), 2);
        chk("R3 tie higher port entry", int'(alloc_idx[2]), 3);
    endtask

    // R2: re-send and exception requests use no entry and cause no rollback
    task automatic t_filter();
        do_reset();
        put(0, 1'b0, 1); req_resend[0] = 1'b1;
        put(1, 1'b0, 2); req_exc[1] = 1'b1;
        put(2, 1'b0, 3);
        step();
        clear_in();
        chk("R2 only clean request granted", int'(alloc_vld), 3'b100);
        chk("R2 clean request entry", int'(alloc_idx[2]), 0);
        put(0, 1'b0, 4);
        step();
        clear_in();
        chk("R2 filtered used no entry", int'(alloc_idx[0]), 1);
        chk("R2 no rollback from filtered", int'(rb_vld), 0);
        step();
        chk("R2 no late rollback", int'(rb_vld), 0);
    endtask

    // R6, R5, R7: partial overflow, rollback delay, release timing
    task automatic t_overflow();
        do_reset();
        put(0, 1'b0, 10); put(1, 1'b0, 11); put(2, 1'b0, 12);
        step();
        clear_in();
        chk("R5 first batch grants", int'(alloc_vld), 3'b111);
        put(0, 1'b0, 20); put(1, 1'b0, 14); put(2, 1'b0, 13);
        step();
        clear_in();
        chk("R6 only oldest placed", int'(alloc_vld), 3'b100);
        chk("R5 last free entry used", int'(alloc_idx[2]), 3);
        chk("R6 no rollback after one cycle", int'(rb_vld), 0);
        step();
        chk("R6 rollback after two cycles", int'(rb_vld), 1);
        chk("R6 rollback index", int'(rb_idx), 14);
        chk("R6 rollback flag", int'(rb_flag), 0);
        // pool full: release two entries while a request arrives in the same cycle
        rel_mask = 4'b0101;
        put(0, 1'b0, 30);
        step();
        clear_in();
        chk("R6 single rollback pulse", int'(rb_vld), 0);
        chk("R7 released slot not usable same cycle", int'(alloc_vld), 0);
        put(0, 1'b0, 31); put(1, 1'b0, 32);
        step();
        clear_in();
        chk("R7 rollback for full-pool request", int'(rb_vld), 1);
        chk("R7 rollback idx for full-pool request", int'(rb_idx), 30);
        chk("R7 both released usable", int'(alloc_vld), 3'b011);
        chk("R7 older gets entry 0", int'(alloc_idx[0]), 0);
        chk("R7 younger gets entry 2", int'(alloc_idx[1]), 2);
        step();
        chk("R9 pool of 4 entries exhausted, no spurious rollback", int'(rb_vld), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_order();
        t_wrap();
        t_filter();
        t_overflow();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule